// File: doc/BRIEF.md
# Program sequencer with hardware repeat

The sequencer owns the word-addressed program counter of a small processor core. On every issued instruction word it picks the next PC. The candidates, lowest priority first, are:

- the next sequential word;
- a taken branch target;
- a zero-overhead loop redirect back to the loop start;
- a debug trap vector on an instruction-address breakpoint;
- an exception vector for an address fault or an illegal instruction.

The fetch unit reads the PC as a byte address, which is the word address times four.

The block also keeps the status word (PSW), the remaining repeat count, a cycle counter and two backup registers. The backup registers hold the return PC and the status word whenever control is vectored. The execute stage reports branches and faults, can load the status word, and arms a repeat loop. The loop start and loop end addresses come from registers held outside the block. Instruction decode and execution belong to other blocks.

Top module: `pseq_top`

## Requirements
- R1: While `rst_n` is low and after it is released, the PC is 0xFFC0, the fetch address is 0x3FF00, and the status word, repeat count, backup PC, backup status and cycle count are all zero.
- R2: `fetch_addr_o` always equals the PC followed by two zero bits.
- R3: When `issue_i` is low, no register changes, whatever the other inputs carry. An issued word with no redirect advances the PC by one, and the PC wraps from 0xFFFF to 0x0000.
- R4: An issued taken branch loads the target into the PC. This also holds when the PC equals the loop end: the repeat count and the repeat bit then stay unchanged.
- R5: If the repeat bit (status bit 9) is set, the PC equals the loop end, no branch is taken and the count is greater than 1, the next PC is the loop start and the count drops by one.
- R6: If the same loop-end case meets a count of 1 or 0, the repeat bit is cleared, the count becomes 0 and the PC advances by one.
- R7: If debug is enabled and the PC equals the breakpoint address, the PC becomes 0xFFCC even when a branch or loop redirect is pending. Backup PC receives the address the word would otherwise have gone to, and backup status receives the status the word would otherwise have produced. The live status keeps only the mode bit (bit 15). Loop count bookkeeping still takes place.
- R8: An address fault sends the PC to 0xFFC4 and an illegal-instruction fault sends it to 0xFFC8; the address fault wins if both are present, and both faults win over a breakpoint. Backup PC receives the faulting PC and backup status receives the old status. The status keeps only F0 (bit 3), F1 (bit 2) and carry (bit 0). Status loads and repeat arming on that word are dropped.
- R9: An issued word without a fault can do two things. `psw_load_i` replaces the status word with `psw_din_i`. `rpt_load_i` loads the repeat count and sets the repeat bit, and this takes precedence over the loop-exit clear and over the status load for that bit.
- R10: The cycle count increases by one for every issued word, including words that are vectored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_i | input | 1 | An instruction word at the current PC completes this cycle |
| br_taken_i | input | 1 | The word takes a branch |
| br_target_i | input | 16 | Branch target word address |
| exc_addr_i | input | 1 | Address fault on this word |
| exc_ill_i | input | 1 | Illegal instruction on this word |
| rpt_load_i | input | 1 | Arm a repeat loop |
| rpt_count_i | input | 16 | Iteration count loaded when arming |
| rpt_start_i | input | 16 | Loop start word address |
| rpt_end_i | input | 16 | Loop end word address |
| psw_load_i | input | 1 | Replace the status word |
| psw_din_i | input | 16 | New status word |
| dbg_en_i | input | 1 | Breakpoint enable |
| bp_addr_i | input | 16 | Breakpoint word address |
| pc_o | output | 16 | Program counter (word address) |
| fetch_addr_o | output | 18 | Fetch byte address |
| psw_o | output | 16 | Status word |
| rpt_count_o | output | 16 | Remaining repeat count |
| bpc_o | output | 16 | Backup PC |
| bpsw_o | output | 16 | Backup status word |
| cycles_o | output | 32 | Issued word count |

## Verification
The assertions assume that every request input is meaningful only in a cycle where `issue_i` is high. The exceptions are the loop end, loop start and breakpoint registers, which must stay stable across an issued word.

The stimulus changes inputs only at the falling edge. It holds the loop bounds fixed while a loop is armed. It sets fault, branch and status-load requests together on purpose, so that every priority ordering is reached. It also drives all of those requests with `issue_i` low, to show that they are ignored.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  localparam int PSW_W  = 16;
  localparam int PSW_SM = 15;
  localparam int PSW_RP = 9;
  localparam int PSW_F0 = 3;
  localparam int PSW_F1 = 2;
  localparam int PSW_C  = 0;

  localparam logic [PSW_W-1:0] KEEP_ON_EXC =
    (16'h0001 << PSW_F0) | (16'h0001 << PSW_F1) | (16'h0001 << PSW_C);
  localparam logic [PSW_W-1:0] KEEP_ON_DBG = 16'h0001 << PSW_SM;

  typedef enum logic [1:0] {FLOW_SEQ, FLOW_BRANCH, FLOW_LOOP, FLOW_EXIT} flow_e;
  typedef enum logic [1:0] {TRAP_NONE, TRAP_ADDR, TRAP_ILL, TRAP_DBG} trap_e;
endpackage

// File: rtl/pseq_select.sv
module pseq_select
  import pseq_pkg::*;
#(
  parameter int PC_W = 16,
  parameter logic [PC_W-1:0] VEC_ADDR = '0,
  parameter logic [PC_W-1:0] VEC_ILL  = '0,
  parameter logic [PC_W-1:0] VEC_DBG  = '0
) (
  input  logic [PC_W-1:0] pc_i,
  input  logic            br_taken_i,
  input  logic [PC_W-1:0] br_target_i,
  input  logic            rpt_on_i,
  input  logic            rpt_last_i,
  input  logic [PC_W-1:0] rpt_start_i,
  input  logic [PC_W-1:0] rpt_end_i,
  input  logic            exc_addr_i,
  input  logic            exc_ill_i,
  input  logic            dbg_en_i,
  input  logic [PC_W-1:0] bp_addr_i,
  output flow_e           flow_o,
  output trap_e           trap_o,
  output logic [PC_W-1:0] flow_pc_o,
  output logic [PC_W-1:0] next_pc_o
);
  localparam logic [PC_W-1:0] PC_ONE = {{(PC_W-1){1'b0}}, 1'b1};

  logic [PC_W-1:0] seq_pc;
  logic            at_loop_end;
  logic            bp_hit;

  assign seq_pc      = pc_i + PC_ONE;
  assign at_loop_end = rpt_on_i && (pc_i == rpt_end_i);
  assign bp_hit      = dbg_en_i && (pc_i == bp_addr_i);

  // Ordinary flow: branch beats the loop-end redirect.
  always_comb begin
    flow_o    = FLOW_SEQ;
    flow_pc_o = seq_pc;
    if (br_taken_i) begin
      flow_o    = FLOW_BRANCH;
      flow_pc_o = br_target_i;
    end else if (at_loop_end) begin
      if (rpt_last_i) begin
        flow_o    = FLOW_EXIT;
        flow_pc_o = seq_pc;
      end else begin
        flow_o    = FLOW_LOOP;
        flow_pc_o = rpt_start_i;
      end
    end
  end

  // Vectoring: faults first, then the breakpoint, then ordinary flow.
  always_comb begin
    trap_o    = TRAP_NONE;
    next_pc_o = flow_pc_o;
    if (exc_addr_i) begin
      trap_o    = TRAP_ADDR;
      next_pc_o = VEC_ADDR;
    end else if (exc_ill_i) begin
      trap_o    = TRAP_ILL;
      next_pc_o = VEC_ILL;
    end else if (bp_hit) begin
      trap_o    = TRAP_DBG;
      next_pc_o = VEC_DBG;
    end
  end
endmodule

// File: rtl/pseq_loop_ctr.sv
module pseq_loop_ctr
  import pseq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  flow_e            flow_i,
  output logic [CNT_W-1:0] count_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                  cnt_d = load_val_i;
    else if (flow_i == FLOW_LOOP) cnt_d = cnt_q - CNT_ONE;
    else if (flow_i == FLOW_EXIT) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;
  assign last_o  = (cnt_q <= CNT_ONE);

  assert_loop_dec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && flow_i == FLOW_LOOP) |=> (count_o == $past(count_o) - CNT_ONE));

  assert_exit_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !load_i && flow_i == FLOW_EXIT) |=> (count_o == '0));

  assert_arm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && load_i) |=> (count_o == $past(load_val_i)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(count_o));
endmodule

// File: rtl/pseq_status.sv
module pseq_status
  import pseq_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_i,
  input  trap_e            trap_i,
  input  flow_e            flow_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic [PC_W-1:0]  flow_pc_i,
  input  logic             psw_load_i,
  input  logic [PSW_W-1:0] psw_din_i,
  input  logic             rpt_load_i,
  output logic [PSW_W-1:0] psw_o,
  output logic             rpt_on_o,
  output logic [PC_W-1:0]  bpc_o,
  output logic [PSW_W-1:0] bpsw_o
);
  logic [PSW_W-1:0] psw_q, psw_d, bpsw_q, bpsw_d, plain_psw;
  logic [PC_W-1:0]  bpc_q, bpc_d;
  logic             is_fault;

  assign is_fault = (trap_i == TRAP_ADDR) || (trap_i == TRAP_ILL);

  // Status the word would produce when not faulting.
  always_comb begin
    plain_psw = psw_load_i ? psw_din_i : psw_q;
    if (flow_i == FLOW_EXIT) plain_psw[PSW_RP] = 1'b0;
    if (rpt_load_i)          plain_psw[PSW_RP] = 1'b1;
  end

  always_comb begin
    psw_d  = plain_psw;
    bpc_d  = bpc_q;
    bpsw_d = bpsw_q;
    if (is_fault) begin
      psw_d  = psw_q & KEEP_ON_EXC;
      bpc_d  = pc_i;
      bpsw_d = psw_q;
    end else if (trap_i == TRAP_DBG) begin
      psw_d  = plain_psw & KEEP_ON_DBG;
      bpc_d  = flow_pc_i;
      bpsw_d = plain_psw;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psw_q  <= '0;
      bpc_q  <= '0;
      bpsw_q <= '0;
    end else if (issue_i) begin
      psw_q  <= psw_d;
      bpc_q  <= bpc_d;
      bpsw_q <= bpsw_d;
    end
  end

  assign psw_o    = psw_q;
  assign rpt_on_o = psw_q[PSW_RP];
  assign bpc_o    = bpc_q;
  assign bpsw_o   = bpsw_q;

  assert_fault_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && is_fault) |=> ((psw_o & ~KEEP_ON_EXC) == '0 && bpc_o == $past(pc_i)));

  assert_dbg_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && trap_i == TRAP_DBG) |=> ((psw_o & ~KEEP_ON_DBG) == '0));

  assert_exit_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && trap_i == TRAP_NONE && flow_i == FLOW_EXIT && !rpt_load_i) |=> !rpt_on_o);

  assert_arm_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && !is_fault && rpt_load_i) |=> bpsw_o[PSW_RP] || rpt_on_o);

  assert_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> ($stable(psw_o) && $stable(bpc_o) && $stable(bpsw_o)));
endmodule

// File: rtl/pseq_top.sv
module pseq_top
  import pseq_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int CNT_W = 16,
  parameter int CYC_W = 32,
  parameter logic [PC_W-1:0] RESET_PC = 16'hFFC0,
  parameter logic [PC_W-1:0] VEC_ADDR = 16'hFFC4,
  parameter logic [PC_W-1:0] VEC_ILL  = 16'hFFC8,
  parameter logic [PC_W-1:0] VEC_DBG  = 16'hFFCC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_i,
  input  logic              br_taken_i,
  input  logic [PC_W-1:0]   br_target_i,
  input  logic              exc_addr_i,
  input  logic              exc_ill_i,
  input  logic              rpt_load_i,
  input  logic [CNT_W-1:0]  rpt_count_i,
  input  logic [PC_W-1:0]   rpt_start_i,
  input  logic [PC_W-1:0]   rpt_end_i,
  input  logic              psw_load_i,
  input  logic [PSW_W-1:0]  psw_din_i,
  input  logic              dbg_en_i,
  input  logic [PC_W-1:0]   bp_addr_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [PC_W+1:0]   fetch_addr_o,
  output logic [PSW_W-1:0]  psw_o,
  output logic [CNT_W-1:0]  rpt_count_o,
  output logic [PC_W-1:0]   bpc_o,
  output logic [PSW_W-1:0]  bpsw_o,
  output logic [CYC_W-1:0]  cycles_o
);
  localparam logic [PC_W-1:0]  PC_ONE  = {{(PC_W-1){1'b0}}, 1'b1};
  localparam logic [CYC_W-1:0] CYC_ONE = {{(CYC_W-1){1'b0}}, 1'b1};

  logic [PC_W-1:0]  pc_q, pc_d, flow_pc;
  logic [CYC_W-1:0] cyc_q, cyc_d;
  flow_e            flow;
  trap_e            trap;
  logic             rpt_on, rpt_last, loop_adv;

  pseq_select #(
    .PC_W(PC_W), .VEC_ADDR(VEC_ADDR), .VEC_ILL(VEC_ILL), .VEC_DBG(VEC_DBG)
  ) i_select (
    .pc_i(pc_q), .br_taken_i(br_taken_i), .br_target_i(br_target_i),
    .rpt_on_i(rpt_on), .rpt_last_i(rpt_last),
    .rpt_start_i(rpt_start_i), .rpt_end_i(rpt_end_i),
    .exc_addr_i(exc_addr_i), .exc_ill_i(exc_ill_i),
    .dbg_en_i(dbg_en_i), .bp_addr_i(bp_addr_i),
    .flow_o(flow), .trap_o(trap), .flow_pc_o(flow_pc), .next_pc_o(pc_d)
  );

  // Count bookkeeping runs on every non-faulting issued word, breakpoints included.
  assign loop_adv = issue_i && (trap != TRAP_ADDR) && (trap != TRAP_ILL);

  pseq_loop_ctr #(.CNT_W(CNT_W)) i_loop (
    .clk(clk), .rst_n(rst_n), .adv_i(loop_adv),
    .load_i(rpt_load_i), .load_val_i(rpt_count_i), .flow_i(flow),
    .count_o(rpt_count_o), .last_o(rpt_last)
  );

  pseq_status #(.PC_W(PC_W)) i_status (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .trap_i(trap), .flow_i(flow),
    .pc_i(pc_q), .flow_pc_i(flow_pc),
    .psw_load_i(psw_load_i), .psw_din_i(psw_din_i), .rpt_load_i(rpt_load_i),
    .psw_o(psw_o), .rpt_on_o(rpt_on), .bpc_o(bpc_o), .bpsw_o(bpsw_o)
  );

  assign cyc_d = cyc_q + CYC_ONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= RESET_PC;
      cyc_q <= '0;
    end else if (issue_i) begin
      pc_q  <= pc_d;
      cyc_q <= cyc_d;
    end
  end

  assign pc_o         = pc_q;
  assign fetch_addr_o = {pc_q, 2'b00};
  assign cycles_o     = cyc_q;

  assert_seq_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && trap == TRAP_NONE && flow == FLOW_SEQ) |=> (pc_o == $past(pc_o) + PC_ONE));

  assert_pc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> ($stable(pc_o) && $stable(cycles_o)));

  assert_branch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && br_taken_i && !exc_addr_i && !exc_ill_i && !(dbg_en_i && pc_o == bp_addr_i))
      |=> (pc_o == $past(br_target_i)));

  assert_dbg_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && dbg_en_i && pc_o == bp_addr_i && !exc_addr_i && !exc_ill_i) |=> (pc_o == VEC_DBG));

  assert_addr_vec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && exc_addr_i) |=> (pc_o == VEC_ADDR));

  assert_cycles_R10: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |=> (cycles_o == $past(cycles_o) + CYC_ONE));
endmodule

// File: tb/test_pseq_top.sv
module test_pseq_top;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n;
  logic        issue, br_taken, exc_addr, exc_ill, rpt_load, psw_load, dbg_en;
  logic [15:0] br_target, rpt_count, rpt_start, rpt_end, psw_din, bp_addr;
  logic [15:0] pc, psw, cnt, bpc, bpsw;
  logic [17:0] fetch;
  logic [31:0] cycles;

  int checks = 0;
  int errors = 0;

  // Behavioural reference state
  logic [15:0] m_pc, m_psw, m_cnt, m_bpc, m_bpsw;
  logic [31:0] m_cyc;

  pseq_top i_pseq_top (
    .clk(clk), .rst_n(rst_n), .issue_i(issue),
    .br_taken_i(br_taken), .br_target_i(br_target),
    .exc_addr_i(exc_addr), .exc_ill_i(exc_ill),
    .rpt_load_i(rpt_load), .rpt_count_i(rpt_count),
    .rpt_start_i(rpt_start), .rpt_end_i(rpt_end),
    .psw_load_i(psw_load), .psw_din_i(psw_din),
    .dbg_en_i(dbg_en), .bp_addr_i(bp_addr),
    .pc_o(pc), .fetch_addr_o(fetch), .psw_o(psw), .rpt_count_o(cnt),
    .bpc_o(bpc), .bpsw_o(bpsw), .cycles_o(cycles)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "pc", {16'h0, pc}, {16'h0, m_pc});
    chk("R2", "fetch", {14'h0, fetch}, {14'h0, m_pc, 2'b00});
    chk(tag, "psw", {16'h0, psw}, {16'h0, m_psw});
    chk(tag, "count", {16'h0, cnt}, {16'h0, m_cnt});
    chk(tag, "bpc", {16'h0, bpc}, {16'h0, m_bpc});
    chk(tag, "bpsw", {16'h0, bpsw}, {16'h0, m_bpsw});
    chk("R10", "cycles", cycles, m_cyc);
  endtask

  // Reference next-state, written from the requirements.
  task automatic model_step();
    logic [15:0] go_pc, would;
    bit looping, leaving;
    if (!issue) return;
    m_cyc = m_cyc + 1;
    looping = 0; leaving = 0;
    if (br_taken) go_pc = br_target;
    else if (m_psw[9] && m_pc == rpt_end) begin
      if (m_cnt > 1) begin looping = 1; go_pc = rpt_start; end
      else begin leaving = 1; go_pc = m_pc + 16'd1; end
    end else go_pc = m_pc + 16'd1;

    if (exc_addr || exc_ill) begin
      m_bpc  = m_pc;
      m_bpsw = m_psw;
      m_psw  = m_psw & 16'h000D;
      m_pc   = exc_addr ? 16'hFFC4 : 16'hFFC8;
    end else begin
      would = psw_load ? psw_din : m_psw;
      if (leaving)  would[9] = 1'b0;
      if (rpt_load) would[9] = 1'b1;
      if (rpt_load)     m_cnt = rpt_count;
      else if (looping) m_cnt = m_cnt - 16'd1;
      else if (leaving) m_cnt = 16'd0;
      if (dbg_en && m_pc == bp_addr) begin
        m_bpc  = go_pc;
        m_bpsw = would;
        m_psw  = would & 16'h8000;
        m_pc   = 16'hFFCC;
      end else begin
        m_psw = would;
        m_pc  = go_pc;
      end
    end
  endtask

  task automatic clear_req();
    issue = 0; br_taken = 0; exc_addr = 0; exc_ill = 0;
    rpt_load = 0; psw_load = 0;
  endtask

  task automatic tick(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare_all(tag);
    clear_req();
  endtask

  task automatic step_n(input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      issue = 1;
      tick(tag);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    errors++;
    $display("FAIL R3 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_req();
    dbg_en = 0; bp_addr = 16'h0; br_target = 16'h0; rpt_count = 16'h0;
    rpt_start = 16'h0101; rpt_end = 16'h0103; psw_din = 16'h0;
    m_pc = 16'hFFC0; m_psw = 0; m_cnt = 0; m_bpc = 0; m_bpsw = 0; m_cyc = 0;
    rst_n = 0;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    compare_all("R1");
    rst_n = 1;
    @(negedge clk);
    compare_all("R1");

    // R3: requests without issue are ignored
    br_taken = 1; br_target = 16'h1234; exc_addr = 1; exc_ill = 1;
    rpt_load = 1; rpt_count = 16'd9; psw_load = 1; psw_din = 16'hFFFF;
    dbg_en = 1; bp_addr = 16'hFFC0;
    tick("R3");
    dbg_en = 0;

    step_n(2, "R3");
    issue = 1; psw_load = 1; psw_din = 16'h88AF;  // R9 status load
    tick("R9");

    issue = 1; br_taken = 1; br_target = 16'h0100;  // R4
    tick("R4");
    issue = 1; rpt_load = 1; rpt_count = 16'd3;     // R9 arm
    tick("R9");
    step_n(10, "R5 R6");                            // R5 loops, R6 exit

    // R4: branch at loop end keeps the loop armed
    issue = 1; rpt_load = 1; rpt_count = 16'd2; br_taken = 1; br_target = 16'h0101;
    tick("R9");
    step_n(2, "R5");
    issue = 1; br_taken = 1; br_target = 16'h0200;
    tick("R4");
    issue = 1; br_taken = 1; br_target = 16'h0103;
    tick("R4");
    step_n(1, "R5");

    // R7: breakpoint overrides a branch at loop end
    dbg_en = 1; bp_addr = 16'h0103;
    step_n(2, "R7");
    issue = 1; br_taken = 1; br_target = 16'h0300;
    tick("R7");

    // R7: breakpoint during a loop redirect
    issue = 1; br_taken = 1; br_target = 16'h0100; psw_load = 1; psw_din = 16'h8004;
    tick("R4");
    issue = 1; rpt_load = 1; rpt_count = 16'd2;
    tick("R9");
    step_n(3, "R7");
    dbg_en = 0;

    // R8: faults
    issue = 1; psw_load = 1; psw_din = 16'hFFFF;
    tick("R9");
    issue = 1; exc_addr = 1; rpt_load = 1; rpt_count = 16'd7; psw_load = 1; psw_din = 16'h1234;
    tick("R8");
    issue = 1; psw_load = 1; psw_din = 16'hFFFF;
    tick("R9");
    issue = 1; exc_ill = 1; br_taken = 1; br_target = 16'h0400;
    tick("R8");
    dbg_en = 1; bp_addr = m_pc;
    issue = 1; exc_ill = 1; exc_addr = 1;
    tick("R8");
    dbg_en = 0;

    // R3: wrap
    issue = 1; br_taken = 1; br_target = 16'hFFFF;
    tick("R4");
    step_n(2, "R3");

    // R6: arm with zero count, leave on first pass
    issue = 1; br_taken = 1; br_target = 16'h0102;
    tick("R4");
    issue = 1; rpt_load = 1; rpt_count = 16'd0;
    tick("R9");
    step_n(2, "R6");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule